// File: doc/BRIEF.md
# PD Transmit Acknowledge Supervisor with Reset Escalation

This block supervises the transmit side of a USB Power Delivery port. When the port asks to send a message, the supervisor issues a send strobe to the packet engine and waits for the line to go quiet. It then counts acknowledge-timeout ticks while it waits for a GoodCRC reply. A missing reply leads to a resend, up to a programmed number of retries. When the retries are used up, the block can move on to a soft reset message, which gets the same retry budget. If that also goes unanswered, the block can move on to a hard reset.

A hard reset can also be requested by hand. That request is latched into a pending bit that clears itself once the hard reset strobe is issued. It overrides any sequence in progress. A separate PD-logic reset input returns the supervisor to idle. It has no effect on the configuration inputs, which are plain levels. Packet encoding and line coding belong to the neighbouring blocks.

Top module: `pd_tx_escalator`

## Requirements
- R1: In idle, a `send_req` high at a rising edge puts `send_pkt` high for exactly the next cycle, and `busy` stays high from then until the sequence returns to idle. In idle `busy` is low.
- R2: After `tx_done` ends a transmission, the acknowledge window closes on the `ACK_TICKS`-th clock with `tick` high (default 4). A `gcrc_rx` seen on or before that closing clock counts as an acknowledge.
- R3: With `cfg_auto_retry` high and retry field N (0..3), a message is transmitted at most N+1 times. With `cfg_auto_retry` low or N = 0 it is transmitted once.
- R4: An acknowledged normal message raises `irq_sent` for one cycle and returns to idle. An acknowledged soft reset returns to idle without any interrupt.
- R5: When the attempts for a normal message are exhausted, `irq_retry_fail` pulses for one cycle. The next cycle carries `send_soft` if `cfg_auto_soft` is high; otherwise the block returns to idle.
- R6: A soft reset message uses the same retry budget as a normal message. When that budget is exhausted, `irq_soft_fail` pulses and a hard reset follows only if `cfg_auto_hard` is high.
- R7: A `hard_req` pulse sets `hard_pend`. On the next clock the sequence abandons whatever it was doing and issues `send_hard`, and `hard_pend` clears on the clock after the strobe.
- R8: After `send_hard`, the first `tx_done` raises `irq_hard_sent` for one cycle and returns to idle.
- R9: A `send_req` that arrives while `busy` is high is ignored and starts no extra transmission.
- R10: `pd_rst` returns the supervisor to idle and drops `hard_pend` on the next clock.
- R11: After `rst`, all strobes, all interrupts, `busy` and `hard_pend` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_rst | input | 1 | PD-logic reset: sequence state back to idle |
| send_req | input | 1 | Request to transmit a prepared message |
| tx_done | input | 1 | Packet engine finished the current transmission |
| gcrc_rx | input | 1 | GoodCRC acknowledge received strobe |
| tick | input | 1 | Acknowledge-timeout time base tick |
| hard_req | input | 1 | Manual hard reset request pulse |
| cfg_auto_retry | input | 1 | Enable automatic resends |
| cfg_retries | input | 2 | Retry count N, giving N+1 transmissions |
| cfg_auto_soft | input | 1 | Escalate to soft reset after retry failure |
| cfg_auto_hard | input | 1 | Escalate to hard reset after soft reset failure |
| send_pkt | output | 1 | Strobe: transmit the prepared message |
| send_soft | output | 1 | Strobe: transmit a soft reset message |
| send_hard | output | 1 | Strobe: transmit a hard reset |
| irq_sent | output | 1 | Pulse: message acknowledged |
| irq_retry_fail | output | 1 | Pulse: all message attempts unanswered |
| irq_soft_fail | output | 1 | Pulse: all soft reset attempts unanswered |
| irq_hard_sent | output | 1 | Pulse: hard reset transmitted |
| busy | output | 1 | A sequence is in progress |
| hard_pend | output | 1 | Manual hard reset request latched, not yet issued |

## Verification
The hardest state to reach from the ports is the full chain in which every normal attempt and every soft reset attempt times out before a hard reset goes out. The same is true of a manual hard reset that lands partway through an acknowledge wait. The bench drives a small responder model that answers each send strobe with `tx_done`, keeps `tick` running, and acknowledges or interrupts only the transmission whose running index a table row names. This lets one table reach any step of the escalation chain. A directed test then steps `tick` by hand to hit the exact closing clock of the window, including a GoodCRC that arrives on that same clock.

// File: rtl/pd_tx_esc_pkg.sv
package pd_tx_esc_pkg;

    localparam int RETRY_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PKT_SEND,
        ST_SOFT_SEND,
        ST_TX_WAIT,
        ST_ACK_WAIT,
        ST_HARD_SEND,
        ST_HARD_WAIT
    } seq_state_e;

    typedef enum logic {
        KIND_PKT,
        KIND_SOFT
    } tx_kind_e;

    typedef struct packed {
        logic               auto_retry;
        logic [RETRY_W-1:0] retries;
        logic               auto_soft;
        logic               auto_hard;
    } esc_cfg_t;

    typedef struct packed {
        logic sent;
        logic retry_fail;
        logic soft_fail;
        logic hard_sent;
    } esc_irq_t;

    function automatic logic may_retry(esc_cfg_t c, logic [RETRY_W-1:0] used);
        return c.auto_retry && (used < c.retries);
    endfunction

    function automatic logic is_hard_state(seq_state_e s);
        return (s == ST_HARD_SEND) || (s == ST_HARD_WAIT);
    endfunction

endpackage

// File: rtl/pd_tx_ack_timer.sv
module pd_tx_ack_timer #(
    parameter int ACK_TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(ACK_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(ACK_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/pd_tx_attempt_ctr.sv
module pd_tx_attempt_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/pd_tx_seq_fsm.sv
module pd_tx_seq_fsm
    import pd_tx_esc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               send_req,
    input  logic               tx_done,
    input  logic               gcrc_rx,
    input  logic               ack_expired,
    input  logic               hard_pend,
    input  esc_cfg_t           cfg,
    input  logic [RETRY_W-1:0] used,
    output seq_state_e         state,
    output logic               ctr_clr,
    output logic               ctr_inc,
    output esc_irq_t           irq
);
    seq_state_e state_n;
    tx_kind_e   kind_q, kind_n;
    esc_irq_t   irq_n;

    always_comb begin
        state_n = state;
        kind_n  = kind_q;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        irq_n   = '0;
        if (hard_pend && !is_hard_state(state)) begin
            state_n = ST_HARD_SEND;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (send_req) begin
                        state_n = ST_PKT_SEND;
                        kind_n  = KIND_PKT;
                        ctr_clr = 1'b1;
                    end
                end
                ST_PKT_SEND, ST_SOFT_SEND: state_n = ST_TX_WAIT;
                ST_TX_WAIT: begin
                    if (tx_done) state_n = ST_ACK_WAIT;
                end
                ST_ACK_WAIT: begin
                    if (gcrc_rx) begin
                        state_n    = ST_IDLE;
                        irq_n.sent = (kind_q == KIND_PKT);
                    end else if (ack_expired) begin
                        if (may_retry(cfg, used)) begin
                            ctr_inc = 1'b1;
                            state_n = (kind_q == KIND_PKT) ? ST_PKT_SEND : ST_SOFT_SEND;
                        end else if (kind_q == KIND_PKT) begin
                            irq_n.retry_fail = 1'b1;
                            if (cfg.auto_soft) begin
                                state_n = ST_SOFT_SEND;
                                kind_n  = KIND_SOFT;
                                ctr_clr = 1'b1;
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end else begin
                            irq_n.soft_fail = 1'b1;
                            state_n = cfg.auto_hard ? ST_HARD_SEND : ST_IDLE;
                        end
                    end
                end
                ST_HARD_SEND: state_n = ST_HARD_WAIT;
                ST_HARD_WAIT: begin
                    if (tx_done) begin
                        state_n         = ST_IDLE;
                        irq_n.hard_sent = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind_q <= KIND_PKT;
            irq    <= '0;
        end else begin
            state  <= state_n;
            kind_q <= kind_n;
            irq    <= irq_n;
        end
    end
endmodule

// File: rtl/pd_tx_escalator.sv
module pd_tx_escalator
    import pd_tx_esc_pkg::*;
#(
    parameter int ACK_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_rst,
    input  logic       send_req,
    input  logic       tx_done,
    input  logic       gcrc_rx,
    input  logic       tick,
    input  logic       hard_req,
    input  logic       cfg_auto_retry,
    input  logic [1:0] cfg_retries,
    input  logic       cfg_auto_soft,
    input  logic       cfg_auto_hard,
    output logic       send_pkt,
    output logic       send_soft,
    output logic       send_hard,
    output logic       irq_sent,
    output logic       irq_retry_fail,
    output logic       irq_soft_fail,
    output logic       irq_hard_sent,
    output logic       busy,
    output logic       hard_pend
);
    logic               seq_rst;
    esc_cfg_t           cfg;
    seq_state_e         state;
    logic               ack_expired;
    logic               ctr_clr, ctr_inc;
    logic [RETRY_W-1:0] used;
    esc_irq_t           irq;

    assign seq_rst = rst || pd_rst;
    assign cfg     = '{auto_retry: cfg_auto_retry, retries: cfg_retries,
                       auto_soft: cfg_auto_soft, auto_hard: cfg_auto_hard};

    always_ff @(posedge clk) begin
        if (seq_rst) begin
            hard_pend <= 1'b0;
        end else begin
            hard_pend <= hard_req || (hard_pend && (state != ST_HARD_SEND));
        end
    end

    pd_tx_ack_timer #(.ACK_TICKS(ACK_TICKS)) u_timer (
        .clk     (clk),
        .rst     (seq_rst),
        .run     (state == ST_ACK_WAIT),
        .tick    (tick),
        .expired (ack_expired)
    );

    pd_tx_attempt_ctr #(.W(RETRY_W)) u_ctr (
        .clk   (clk),
        .rst   (seq_rst),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .count (used)
    );

    pd_tx_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (seq_rst),
        .send_req    (send_req),
        .tx_done     (tx_done),
        .gcrc_rx     (gcrc_rx),
        .ack_expired (ack_expired),
        .hard_pend   (hard_pend),
        .cfg         (cfg),
        .used        (used),
        .state       (state),
        .ctr_clr     (ctr_clr),
        .ctr_inc     (ctr_inc),
        .irq         (irq)
    );

    assign send_pkt       = (state == ST_PKT_SEND);
    assign send_soft      = (state == ST_SOFT_SEND);
    assign send_hard      = (state == ST_HARD_SEND);
    assign busy           = (state != ST_IDLE);
    assign irq_sent       = irq.sent;
    assign irq_retry_fail = irq.retry_fail;
    assign irq_soft_fail  = irq.soft_fail;
    assign irq_hard_sent  = irq.hard_sent;
endmodule

// File: rtl/pd_tx_esc_chk.sv
module pd_tx_esc_chk (
    input logic clk,
    input logic rst,
    input logic pd_rst,
    input logic send_req,
    input logic tx_done,
    input logic gcrc_rx,
    input logic hard_req,
    input logic send_pkt,
    input logic send_hard,
    input logic irq_sent,
    input logic irq_retry_fail,
    input logic irq_hard_sent,
    input logic busy,
    input logic hard_pend
);
    AST_IDLE_REQ_STARTS: assert property (@(posedge clk) disable iff (rst || pd_rst)
        (send_req && !busy && !hard_pend) |=> send_pkt); // R1

    AST_SENT_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst || pd_rst)
        irq_sent |-> $past(gcrc_rx)); // R4

    AST_RETRY_FAIL_NO_RESEND: assert property (@(posedge clk) disable iff (rst || pd_rst)
        irq_retry_fail |-> !send_pkt); // R5

    AST_HARD_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst || pd_rst)
        (send_hard && !hard_req) |=> !hard_pend); // R7

    AST_HARD_SENT_AFTER_TX: assert property (@(posedge clk) disable iff (rst || pd_rst)
        irq_hard_sent |-> $past(tx_done)); // R8

    AST_PDRST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        pd_rst |=> (!busy && !hard_pend)); // R10
endmodule

bind pd_tx_escalator pd_tx_esc_chk u_chk (.*);

// File: tb/tb_pd_tx_escalator.sv
module tb_pd_tx_escalator;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       ar;
        logic [1:0] n;
        logic       asoft;
        logic       ahard;
        logic [3:0] ack_at;
        logic [3:0] hard_at;
        logic [3:0] e_pkt;
        logic [3:0] e_soft;
        logic [3:0] e_hard;
        logic [3:0] e_sent;
        logic [3:0] e_rf;
        logic [3:0] e_sf;
        logic [3:0] e_hs;
        logic       spam;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd3, 1'b1, 1'b1, 4'd0,  4'd15, 4'd1, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 1'b0},
        '{1'b1, 2'd3, 1'b1, 1'b1, 4'd2,  4'd15, 4'd3, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 1'b0},
        '{1'b1, 2'd3, 1'b1, 1'b1, 4'd15, 4'd15, 4'd4, 4'd4, 4'd1, 4'd0, 4'd1, 4'd1, 4'd1, 1'b0},
        '{1'b0, 2'd3, 1'b1, 1'b1, 4'd15, 4'd15, 4'd1, 4'd1, 4'd1, 4'd0, 4'd1, 4'd1, 4'd1, 1'b0},
        '{1'b1, 2'd0, 1'b0, 1'b0, 4'd15, 4'd15, 4'd1, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 1'b0},
        '{1'b1, 2'd1, 1'b1, 1'b0, 4'd15, 4'd15, 4'd2, 4'd2, 4'd0, 4'd0, 4'd1, 4'd1, 4'd0, 1'b0},
        '{1'b1, 2'd2, 1'b1, 1'b1, 4'd4,  4'd15, 4'd3, 4'd2, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 1'b0},
        '{1'b1, 2'd1, 1'b0, 1'b1, 4'd15, 4'd15, 4'd2, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 1'b0},
        '{1'b1, 2'd2, 1'b1, 1'b1, 4'd3,  4'd15, 4'd3, 4'd1, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 1'b0},
        '{1'b1, 2'd3, 1'b1, 1'b1, 4'd15, 4'd1,  4'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0, 4'd1, 1'b0},
        '{1'b0, 2'd0, 1'b0, 1'b0, 4'd15, 4'd15, 4'd1, 4'd0, 4'd0, 4'd0, 4'd1, 4'd0, 4'd0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1, pd_rst = 1'b0, send_req = 1'b0, tx_done = 1'b0;
    logic gcrc_rx = 1'b0, tick = 1'b0, hard_req = 1'b0;
    logic cfg_auto_retry = 1'b0, cfg_auto_soft = 1'b0, cfg_auto_hard = 1'b0;
    logic [1:0] cfg_retries = 2'd0;
    logic send_pkt, send_soft, send_hard, irq_sent, irq_retry_fail;
    logic irq_soft_fail, irq_hard_sent, busy, hard_pend;

    int n_cmp = 0, n_bad = 0;
    int c_pkt, c_soft, c_hard, c_sent, c_rf, c_sf, c_hs;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pd_tx_escalator #(.ACK_TICKS(4)) dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input vec_t v);
        int txi = 0, cur = 0, cd = 0, quiet = 0;
        logic ack_next = 1'b0, hard_next = 1'b0;
        c_pkt = 0; c_soft = 0; c_hard = 0; c_sent = 0; c_rf = 0; c_sf = 0; c_hs = 0;
        cfg_auto_retry = v.ar; cfg_retries = v.n;
        cfg_auto_soft = v.asoft; cfg_auto_hard = v.ahard;
        tick = 1'b1;
        @(negedge clk) send_req = 1'b1;
        @(negedge clk) send_req = 1'b0;
        for (int c = 0; c < 400; c++) begin
            c_pkt  += int'(send_pkt);
            c_soft += int'(send_soft);
            c_hard += int'(send_hard);
            c_sent += int'(irq_sent);
            c_rf   += int'(irq_retry_fail);
            c_sf   += int'(irq_soft_fail);
            c_hs   += int'(irq_hard_sent);
            tx_done = 1'b0; gcrc_rx = ack_next; hard_req = hard_next;
            ack_next = 1'b0; hard_next = 1'b0;
            send_req = v.spam && busy;
            if (cd == 1) begin
                tx_done = 1'b1;
                if (cur == int'(v.ack_at)) ack_next = 1'b1;
                if (cur == int'(v.hard_at)) hard_next = 1'b1;
            end
            if (cd > 0) cd--;
            if (send_pkt || send_soft || send_hard) begin
                cur = send_hard ? 14 : txi;
                if (!send_hard) txi++;
                cd = 2;
            end
            quiet = (busy || hard_pend) ? 0 : quiet + 1;
            if (quiet > 3) break;
            @(negedge clk);
        end
        send_req = 1'b0; tick = 1'b0; tx_done = 1'b0; gcrc_rx = 1'b0; hard_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 strobes", int'({send_pkt, send_soft, send_hard}), 0);
        chk("R11 irqs", int'({irq_sent, irq_retry_fail, irq_soft_fail, irq_hard_sent}), 0);
        chk("R11 busy/pend", int'({busy, hard_pend}), 0);

        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i]);
            chk($sformatf("R3 row %0d packet sends", i), c_pkt, int'(VECS[i].e_pkt));
            chk($sformatf("R6 row %0d soft sends", i), c_soft, int'(VECS[i].e_soft));
            chk($sformatf("R6 row %0d hard sends", i), c_hard, int'(VECS[i].e_hard));
            chk($sformatf("R4 row %0d sent irq", i), c_sent, int'(VECS[i].e_sent));
            chk($sformatf("R5 row %0d retry-fail irq", i), c_rf, int'(VECS[i].e_rf));
            chk($sformatf("R6 row %0d soft-fail irq", i), c_sf, int'(VECS[i].e_sf));
            chk($sformatf("R8 row %0d hard-sent irq", i), c_hs, int'(VECS[i].e_hs));
            if (VECS[i].spam) chk("R9 busy requests ignored", c_pkt, 1);
            if (VECS[i].hard_at != 4'd15) chk("R7 pending cleared", int'(hard_pend), 0);
        end

        // R2 window boundary, then R10 mid-sequence reset
        cfg_auto_retry = 1'b1; cfg_retries = 2'd1; cfg_auto_soft = 1'b0; cfg_auto_hard = 1'b0;
        @(negedge clk) send_req = 1'b1;
        @(negedge clk) send_req = 1'b0;
        chk("R1 send strobe", int'(send_pkt), 1);
        chk("R1 busy", int'(busy), 1);
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        tick = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 no early resend", int'(send_pkt), 0);
        end
        tick = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk("R2 window holds without ticks", int'({send_pkt, busy}), 1);
        end
        tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk("R2 resend on last tick", int'(send_pkt), 1);
        @(negedge clk) pd_rst = 1'b1;
        @(negedge clk) pd_rst = 1'b0;
        chk("R10 idle after pd reset", int'({busy, send_pkt, send_soft}), 0);

        // R2 acknowledge on the closing clock wins
        @(negedge clk) send_req = 1'b1;
        @(negedge clk) send_req = 1'b0;
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        tick = 1'b1;
        repeat (3) @(negedge clk);
        gcrc_rx = 1'b1;
        @(negedge clk);
        gcrc_rx = 1'b0; tick = 1'b0;
        chk("R2 R4 ack on closing tick", int'(irq_sent), 1);
        chk("R2 no resend", int'({send_pkt, busy}), 0);

        // R7 R8 manual hard reset from idle
        @(negedge clk) hard_req = 1'b1;
        @(negedge clk) hard_req = 1'b0;
        chk("R7 pending set", int'({hard_pend, send_hard}), 2);
        @(negedge clk);
        chk("R7 hard strobe", int'(send_hard), 1);
        @(negedge clk);
        chk("R7 pending self-clears", int'(hard_pend), 0);
        chk("R8 busy during hard", int'(busy), 1);
        tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        chk("R8 hard-sent irq", int'(irq_hard_sent), 1);
        chk("R8 idle after hard", int'(busy), 0);

        // R10 pd reset drops a latched hard request
        hard_req = 1'b1;
        @(negedge clk) hard_req = 1'b0; pd_rst = 1'b1;
        @(negedge clk) pd_rst = 1'b0;
        chk("R10 pending dropped", int'(hard_pend), 0);
        repeat (2) @(negedge clk);
        chk("R10 no hard after drop", int'({send_hard, busy}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule